// File: doc/BRIEF.md
# Bus-width auto-detect control register

This block is one configuration register of a bus-attached network controller. Its main content is a sticky I/O width flag that picks between word-wide and doubleword-wide host I/O. This flag changes the I/O offset map and the width of the I/O resources elsewhere in the chip. The register also holds three enable bits: external request, burst read and burst write. It holds a two-bit select field that chooses between normal operation and external address-detection snooping. The enable bits and the select field are guarded, so the host can change them only while the engine is stopped or suspended.

Host software never writes the width flag directly. A controller that hard reset has left in word mode switches itself to doubleword mode when it sees a doubleword-sized write to the data port at offset 10h. The flag then stays set. Only a hard reset, or a configuration load from non-volatile storage that carries a 0, returns it to word mode. The same load can also set the flag.

The width flag is a two-state machine: `MODE_WORD` and `MODE_DWORD`. It has four named transitions:
- `T_AUTO` goes from `MODE_WORD` to `MODE_DWORD` on a doubleword write to offset 10h.
- `T_EEP_SET` goes to `MODE_DWORD` on a storage load that carries 1.
- `T_EEP_CLR` goes to `MODE_WORD` on a storage load that carries 0, when no `T_AUTO` event occurs in the same cycle.
- `T_HARD` goes to `MODE_WORD` on hard reset and takes priority over every other transition.

Top module: `iomode_cfg_reg`

## Requirements
- R1: While `hard_rst` is high at a clock edge, every stored bit is cleared after that edge. This holds even if a storage load or a doubleword data-port write arrives in the same cycle. `rd_data` then reads 0, `rom_sel` is 1 and all other outputs are 0.
- R2: A write with `io_size` = 2'b10 (doubleword) to `io_ofs` = 5'h10 sets `dword_mode` after the next clock edge.
- R3: Writes to offset 5'h10 with `io_size` of 2'b00 (byte), 2'b01 (word) or 2'b11 (reserved) leave `dword_mode` unchanged. So do writes of any size to any other offset.
- R4: Once set, `dword_mode` stays set through any host write, soft reset or STOP. Host writes to the register's bit 0 have no effect on it.
- R5: A pulse on `eep_ld` loads `eep_dword` into `dword_mode` at the next clock edge. A loaded 1 sets it and a loaded 0 clears it.
- R6: A `T_AUTO` event wins over a storage load of 0 in the same cycle, so `dword_mode` ends up set.
- R7: A write to `io_ofs` = 5'h14 while `stop_st` or `spnd_st` is high stores the guarded fields from the write data: bit 1 external request, bit 2 burst read, bit 3 burst write, bits 5:4 select.
- R8: A write to offset 5'h14 while both `stop_st` and `spnd_st` are low leaves all guarded bits unchanged.
- R9: `soft_rst` and `stop_st` on their own change no bit of the register.
- R10: `rom_sel` is high only when select = 2'b00. `snoop_en` is high only when select = 2'b01. Both are low for 2'b10 and 2'b11.
- R11: `rd_data` always shows the width flag in bit 0 and the guarded fields at the positions given in R7, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Soft reset, active high; has no effect on this register |
| io_ofs | input | ADDR_W (5) | Offset of the host I/O access from the I/O base |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_size | input | 2 | Access size: 00 byte, 01 word, 10 doubleword, 11 reserved |
| io_wdata | input | DATA_W (32) | Host write data |
| stop_st | input | 1 | Engine stopped status |
| spnd_st | input | 1 | Engine suspended status |
| eep_ld | input | 1 | Storage-load strobe |
| eep_dword | input | 1 | Width flag value carried by the storage load |
| rd_data | output | DATA_W (32) | Register read value |
| dword_mode | output | 1 | 1 = doubleword I/O, 0 = word I/O |
| ext_req_en | output | 1 | External request enable |
| burst_rd_en | output | 1 | Burst read enable |
| burst_wr_en | output | 1 | Burst write enable |
| sel_mode | output | 2 | Raw select field |
| rom_sel | output | 1 | Normal operation, expansion ROM or flash selected |
| snoop_en | output | 1 | Internal MII-style bus routed out for address-detection snooping |

## Verification
The width flag is hard to test from the ports because it is sticky. After the first doubleword data-port write, no later host access can show whether another write would have set it. The stimulus therefore pulses hard reset before every single access in the sweep over all 32 offsets and all four size codes. Each access starts from `MODE_WORD`, so each one shows on its own whether it sets the flag. The guarded fields are swept over all 64 write values under all four STOP/SPND combinations. Same-cycle collisions are driven on purpose: hard reset with a load and an auto-set write, and an auto-set write with a load of 0.

// File: rtl/iomode_cfg_pkg.sv
package iomode_cfg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } acc_size_e;

    typedef enum logic {
        MODE_WORD  = 1'b0,
        MODE_DWORD = 1'b1
    } width_state_e;

    // guarded fields, packed in read-data order from bit 5 down to bit 1
    typedef struct packed {
        logic [1:0] sel;
        logic       bwr;
        logic       brd;
        logic       xreq;
    } guard_bits_t;

    localparam int GUARD_W  = $bits(guard_bits_t);
    localparam int GUARD_LO = 1;
    localparam int REG_W    = GUARD_LO + GUARD_W;

endpackage

// File: rtl/iomode_access_dec.sv
module iomode_access_dec
    import iomode_cfg_pkg::*;
#(
    parameter int              ADDR_W  = 5,
    parameter logic [ADDR_W-1:0] DP_OFS  = 5'h10,
    parameter logic [ADDR_W-1:0] CFG_OFS = 5'h14
) (
    input  logic [ADDR_W-1:0] io_ofs,
    input  logic              io_wr,
    input  logic [1:0]        io_size,
    input  logic              stop_st,
    input  logic              spnd_st,
    output logic              auto_hit,
    output logic              cfg_wr_ok
);
    acc_size_e size_e;

    always_comb begin
        size_e    = acc_size_e'(io_size);
        auto_hit  = io_wr && (io_ofs == DP_OFS) && (size_e == SZ_DWORD);
        cfg_wr_ok = io_wr && (io_ofs == CFG_OFS) && (stop_st || spnd_st);
    end

endmodule

// File: rtl/iomode_width_fsm.sv
module iomode_width_fsm
    import iomode_cfg_pkg::*;
(
    input  logic clk,
    input  logic hard_rst,
    input  logic auto_hit,
    input  logic eep_ld,
    input  logic eep_dword,
    output logic dword_mode
);
    width_state_e state_q, state_d;

    // state register (T_HARD has top priority)
    always_ff @(posedge clk) begin
        if (hard_rst) state_q <= MODE_WORD;
        else          state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_WORD: begin
                if (auto_hit)                 state_d = MODE_DWORD; // T_AUTO
                else if (eep_ld && eep_dword) state_d = MODE_DWORD; // T_EEP_SET
            end
            MODE_DWORD: begin
                if (!auto_hit && eep_ld && !eep_dword)
                    state_d = MODE_WORD;                            // T_EEP_CLR
            end
            default: state_d = MODE_WORD;
        endcase
    end

    // outputs
    always_comb begin
        dword_mode = (state_q == MODE_DWORD);
    end

    // R1
    width_hard_clear_chk: assert property (@(posedge clk)
        hard_rst |=> (state_q == MODE_WORD));
    // R2
    width_auto_set_chk: assert property (@(posedge clk) disable iff (hard_rst)
        auto_hit |=> (state_q == MODE_DWORD));
    // R4
    width_sticky_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (state_q == MODE_DWORD && !eep_ld) |=> (state_q == MODE_DWORD));
    // R5
    width_eep_clr_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (eep_ld && !eep_dword && !auto_hit) |=> (state_q == MODE_WORD));

endmodule

// File: rtl/iomode_guard_regs.sv
module iomode_guard_regs
    import iomode_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        hard_rst,
    input  logic        wr_en,
    input  guard_bits_t wdata,
    output guard_bits_t q
);
    always_ff @(posedge clk) begin
        if (hard_rst)   q <= '0;
        else if (wr_en) q <= wdata;
    end

    // R1
    guard_hard_clear_chk: assert property (@(posedge clk)
        hard_rst |=> (q == '0));
    // R8
    guard_locked_chk: assert property (@(posedge clk) disable iff (hard_rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/iomode_cfg_reg.sv
module iomode_cfg_reg
    import iomode_cfg_pkg::*;
#(
    parameter int              ADDR_W  = 5,
    parameter int              DATA_W  = 32,
    parameter logic [ADDR_W-1:0] DP_OFS  = 5'h10,
    parameter logic [ADDR_W-1:0] CFG_OFS = 5'h14
) (
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] io_ofs,
    input  logic              io_wr,
    input  logic [1:0]        io_size,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              stop_st,
    input  logic              spnd_st,
    input  logic              eep_ld,
    input  logic              eep_dword,
    output logic [DATA_W-1:0] rd_data,
    output logic              dword_mode,
    output logic              ext_req_en,
    output logic              burst_rd_en,
    output logic              burst_wr_en,
    output logic [1:0]        sel_mode,
    output logic              rom_sel,
    output logic              snoop_en
);
    logic        auto_hit, cfg_wr_ok;
    guard_bits_t guard_q;
    guard_bits_t guard_wd;

    // soft reset, bit 0 and the upper data bits are deliberately not consumed
    logic unused_ok;
    assign unused_ok = ^{io_wdata[DATA_W-1:REG_W], io_wdata[0], soft_rst};

    iomode_access_dec #(
        .ADDR_W (ADDR_W),
        .DP_OFS (DP_OFS),
        .CFG_OFS(CFG_OFS)
    ) u_dec (
        .io_ofs   (io_ofs),
        .io_wr    (io_wr),
        .io_size  (io_size),
        .stop_st  (stop_st),
        .spnd_st  (spnd_st),
        .auto_hit (auto_hit),
        .cfg_wr_ok(cfg_wr_ok)
    );

    iomode_width_fsm u_fsm (
        .clk       (clk),
        .hard_rst  (hard_rst),
        .auto_hit  (auto_hit),
        .eep_ld    (eep_ld),
        .eep_dword (eep_dword),
        .dword_mode(dword_mode)
    );

    assign guard_wd = guard_bits_t'(io_wdata[REG_W-1:GUARD_LO]);

    iomode_guard_regs u_guard (
        .clk     (clk),
        .hard_rst(hard_rst),
        .wr_en   (cfg_wr_ok),
        .wdata   (guard_wd),
        .q       (guard_q)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[0]                   = dword_mode;
        rd_data[REG_W-1:GUARD_LO]    = guard_q;
        ext_req_en                   = guard_q.xreq;
        burst_rd_en                  = guard_q.brd;
        burst_wr_en                  = guard_q.bwr;
        sel_mode                     = guard_q.sel;
        rom_sel                      = (guard_q.sel == 2'b00);
        snoop_en                     = (guard_q.sel == 2'b01);
    end

    // R10
    sel_decode_chk: assert property (@(posedge clk)
        $onehot0({rom_sel, snoop_en}));
    // R9
    soft_rst_quiet_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (soft_rst && !io_wr && !eep_ld) |=> ($stable(rd_data)));

endmodule

// File: tb/iomode_cfg_reg_tb.sv
`timescale 1ns/1ps
module iomode_cfg_reg_tb;
    logic        clk = 1'b0;
    logic        hard_rst, soft_rst, io_wr, stop_st, spnd_st, eep_ld, eep_dword;
    logic [4:0]  io_ofs;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic [31:0] rd_data;
    logic        dword_mode, ext_req_en, burst_rd_en, burst_wr_en, rom_sel, snoop_en;
    logic [1:0]  sel_mode;

    int errs = 0;
    int checks = 0;

    // bench model of the register
    logic       m_mode;
    logic [4:0] m_guard;

    always #2.5 clk = ~clk;

    iomode_cfg_reg u_dut (
        .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .io_ofs(io_ofs),
        .io_wr(io_wr), .io_size(io_size), .io_wdata(io_wdata), .stop_st(stop_st),
        .spnd_st(spnd_st), .eep_ld(eep_ld), .eep_dword(eep_dword), .rd_data(rd_data),
        .dword_mode(dword_mode), .ext_req_en(ext_req_en), .burst_rd_en(burst_rd_en),
        .burst_wr_en(burst_wr_en), .sel_mode(sel_mode), .rom_sel(rom_sel), .snoop_en(snoop_en)
    );

    task automatic idle();
        hard_rst = 0; soft_rst = 0; io_wr = 0; io_ofs = 0; io_size = 0;
        io_wdata = 0; stop_st = 0; spnd_st = 0; eep_ld = 0; eep_dword = 0;
    endtask

    // apply current inputs for one edge, update model, return at negedge
    task automatic step();
        logic       n_mode;
        logic [4:0] n_guard;
        n_mode  = m_mode;
        n_guard = m_guard;
        if (hard_rst) begin
            n_mode = 0; n_guard = 0;
        end else begin
            if (io_wr && io_ofs == 5'h10 && io_size == 2'b10) n_mode = 1;
            else if (eep_ld) n_mode = eep_dword;
            if (io_wr && io_ofs == 5'h14 && (stop_st || spnd_st)) n_guard = io_wdata[5:1];
        end
        @(posedge clk);
        m_mode = n_mode; m_guard = n_guard;
        @(negedge clk);
        idle();
    endtask

    task automatic check(input string tag);
        logic [39:0] got, exp;
        exp = {26'd0, m_guard, m_mode, m_mode, m_guard[0], m_guard[1], m_guard[2],
               m_guard[4:3], (m_guard[4:3] == 2'b00), (m_guard[4:3] == 2'b01)};
        got = {rd_data, dword_mode, ext_req_en, burst_rd_en, burst_wr_en,
               sel_mode, rom_sel, snoop_en};
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog: got=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        m_mode = 0; m_guard = 0;
        idle();
        hard_rst = 1;
        @(negedge clk);
        // R1 / R6: hard reset collides with load of 1 and auto-set write
        hard_rst = 1; eep_ld = 1; eep_dword = 1;
        io_wr = 1; io_ofs = 5'h10; io_size = 2'b10;
        step();
        check("R1");

        // R2 / R3: sweep every offset and size code from word mode
        for (int o = 0; o < 32; o++) begin
            for (int s = 0; s < 4; s++) begin
                hard_rst = 1; step();
                io_wr = 1; io_ofs = o[4:0]; io_size = s[1:0]; io_wdata = 32'hFFFF_FFFF;
                step();
                if (o == 16 && s == 2) check("R2");
                else check("R3");
            end
        end

        // R4: sticky through host write of bit 0, soft reset, stop
        hard_rst = 1; step();
        io_wr = 1; io_ofs = 5'h10; io_size = 2'b10; step();
        io_wr = 1; io_ofs = 5'h14; io_size = 2'b10; io_wdata = 0; stop_st = 1; step();
        check("R4");
        soft_rst = 1; step(); check("R4");
        stop_st = 1; step(); check("R4");

        // R5: storage load 0 then 1
        eep_ld = 1; eep_dword = 0; step(); check("R5");
        eep_ld = 1; eep_dword = 1; step(); check("R5");
        eep_ld = 1; eep_dword = 0; step(); check("R5");

        // R6: auto-set beats load of 0
        eep_ld = 1; eep_dword = 0; io_wr = 1; io_ofs = 5'h10; io_size = 2'b10;
        step(); check("R6");

        // R7 / R8 / R10 / R11: guarded field sweep across STOP/SPND
        for (int g = 0; g < 4; g++) begin
            for (int d = 0; d < 64; d++) begin
                io_wr = 1; io_ofs = 5'h14; io_size = 2'b10;
                io_wdata = {26'h3FF_FFFF, d[5:0]};
                stop_st = g[0]; spnd_st = g[1];
                step();
                if (g == 0) check("R8");
                else check("R7_R10_R11");
            end
        end

        // R9: soft reset and stop alone leave guarded bits
        io_wr = 1; io_ofs = 5'h14; io_wdata = 32'h3E; spnd_st = 1; step();
        soft_rst = 1; step(); check("R9");
        stop_st = 1; step(); check("R9");
        soft_rst = 1; stop_st = 1; step(); check("R9");

        // R1: hard reset clears guarded bits and mode
        hard_rst = 1; step(); check("R1");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule